// File: doc/BRIEF.md
# Indirect Oscillator Configuration Channel

This block gives software indirect access to a small array of oscillator setting words. Software does not address the oscillator words directly. It loads a data word into an outgoing data register. It then writes a command word that names a function code and a device index and sets a start flag. One cycle later the block runs the transaction. A write copies the outgoing data into the selected oscillator word. A read places the selected oscillator word into a return register. A status register reports completion and any rejection of the command.

The oscillator words are also driven out on a flat output vector, so that clock logic elsewhere in the chip can use them. The number of oscillator words is a parameter from 1 to 16, and so are their reset values. A command is accepted only for function code 1 and a device index below that count. The index is compared across its full 12 bits.

Top module: `cfgch_top`

## Requirements
- R1: After reset, the command register reads 0x00100000, and status, outgoing data and return data read 0. Oscillator word i holds its reset parameter value `OSC_RESET_ALL[32*i +: 32]`.
- R2: The bus has a 2-bit word select. Select 0 is the command register, 1 is status (bit 0 done, bit 1 error, other bits 0), 2 is outgoing data (readable and writable) and 3 is return data. Writes to selects 1 and 3 change nothing.
- R3: A command write stores the written word with bits [19:12], [29:26] and 31 cleared. Device index bits [11:0], function bits [25:20] and direction bit 30 (1 = write) are kept as written.
- R4: Every command write sets status to 0 at the clock edge that takes the write. In the following cycle, status reads 0.
- R5: A command write with bit 31 set completes at the next clock edge, with no command write in between. Done then reads 1, and status holds until the next command write.
- R6: A command is legal only when its function field equals 1 and its device index, taken as a 12-bit unsigned value, is less than `N_OSC`. An illegal command sets error together with done.
- R7: A legal command with direction 1 copies the outgoing data register into the indexed oscillator word.
- R8: A legal command with direction 0 loads the indexed oscillator word into the return register.
- R9: An illegal command leaves the return register and all oscillator words unchanged.
- R10: A command write with bit 31 clear starts nothing. Status stays 0, and the return register and oscillator words are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register word select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| osc_setting | output | 32*N_OSC | Oscillator words, word i at bits [32*i+31:32*i] |

## Verification
The hardest states to reach from the ports are the rejection boundaries. These are a device index exactly equal to `N_OSC`, an index that is legal only in its low bits (such as 0xFFF), and a function field that differs from 1 only in a high bit. A further case is the one-cycle window in which status has been cleared but the command has not yet completed. Random commands are weighted so that indices spread just around `N_OSC` and across the whole 12-bit range, and random junk is placed in the reserved bits. Directed commands hit each boundary. Status is read in the window cycle and again one cycle later, for every command.

// File: rtl/cfgch_pkg.sv
package cfgch_pkg;

    localparam int WORD_W   = 32;
    localparam int MAX_OSC  = 16;
    localparam int DEV_W    = 12;
    localparam int FUNC_W   = 6;

    // Command word; field positions are decoded by software, so they are fixed.
    typedef struct packed {
        logic              start;
        logic              wr_dir;
        logic [3:0]        pad_hi;
        logic [FUNC_W-1:0] func;
        logic [7:0]        pad_lo;
        logic [DEV_W-1:0]  dev;
    } cmd_word_t;

    typedef struct packed {
        logic fault;
        logic done;
    } stat_t;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DOUT = 2'd2,
        SEL_DRTN = 2'd3
    } sel_e;

    localparam logic [FUNC_W-1:0] FUNC_OSC  = 6'd1;
    localparam logic [WORD_W-1:0] CMD_RESET = 32'h0010_0000;

    function automatic cmd_word_t cmd_scrub(input logic [WORD_W-1:0] w);
        cmd_word_t c;
        c        = cmd_word_t'(w);
        c.start  = 1'b0;
        c.pad_hi = '0;
        c.pad_lo = '0;
        return c;
    endfunction

    function automatic logic cmd_legal(input cmd_word_t c, input int unsigned n);
        return (c.func == FUNC_OSC) && (32'(c.dev) < n);
    endfunction

endpackage

// File: rtl/cfgch_cmd_stage.sv
module cfgch_cmd_stage
    import cfgch_pkg::*;
#(
    parameter int N_OSC = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_wr,
    input  logic [WORD_W-1:0]     wdata,
    output cmd_word_t             cmd_q,
    output stat_t                 stat_q,
    output logic                  exec_go,
    output logic                  exec_wr,
    output logic [DEV_W-1:0]      exec_dev
);

    logic pend_q;
    logic legal;

    assign legal    = cmd_legal(cmd_q, N_OSC);
    assign exec_go  = pend_q && legal;
    assign exec_wr  = cmd_q.wr_dir;
    assign exec_dev = cmd_q.dev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= cmd_word_t'(CMD_RESET);
            pend_q <= 1'b0;
            stat_q <= '0;
        end else if (cmd_wr) begin
            // A new command write wins over the status of one completing now.
            cmd_q  <= cmd_scrub(wdata);
            pend_q <= wdata[WORD_W-1];
            stat_q <= '0;
        end else begin
            pend_q <= 1'b0;
            if (pend_q) begin
                stat_q.done  <= 1'b1;
                stat_q.fault <= !legal;
            end
        end
    end

endmodule

// File: rtl/cfgch_osc_array.sv
module cfgch_osc_array
    import cfgch_pkg::*;
#(
    parameter int                           N_OSC         = 4,
    parameter logic [MAX_OSC*WORD_W-1:0]    OSC_RESET_ALL = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_go,
    input  logic [DEV_W-1:0]          idx,
    input  logic [WORD_W-1:0]         wr_data,
    output logic [WORD_W-1:0]         rd_data,
    output logic [N_OSC*WORD_W-1:0]   osc_flat
);

    logic [WORD_W-1:0] osc_q [N_OSC];

    for (genvar gi = 0; gi < N_OSC; gi++) begin : g_osc
        localparam logic [WORD_W-1:0] RST_VAL = OSC_RESET_ALL[gi*WORD_W +: WORD_W];

        always_ff @(posedge clk) begin
            if (rst)
                osc_q[gi] <= RST_VAL;
            else if (wr_go && (idx == DEV_W'(gi)))
                osc_q[gi] <= wr_data;
        end

        assign osc_flat[gi*WORD_W +: WORD_W] = osc_q[gi];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_OSC; i++) begin
            if (idx == DEV_W'(i))
                rd_data = osc_q[i];
        end
    end

endmodule

// File: rtl/cfgch_top.sv
module cfgch_top
    import cfgch_pkg::*;
#(
    parameter int                        N_OSC         = 4,
    parameter logic [MAX_OSC*WORD_W-1:0] OSC_RESET_ALL =
        {384'h0, 32'd40000000, 32'd24576000, 32'd25000000, 32'd50000000}
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_wr,
    input  logic [1:0]                reg_sel,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    output logic [N_OSC*32-1:0]       osc_setting
);

    sel_e              sel;
    cmd_word_t         cmd_q;
    stat_t             stat_q;
    logic              exec_go;
    logic              exec_wr;
    logic [DEV_W-1:0]  exec_dev;
    logic [WORD_W-1:0] dout_q;
    logic [WORD_W-1:0] rtn_q;
    logic [WORD_W-1:0] osc_rd;

    assign sel = sel_e'(reg_sel);

    cfgch_cmd_stage #(.N_OSC(N_OSC)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (reg_wr && (sel == SEL_CMD)),
        .wdata    (reg_wdata),
        .cmd_q    (cmd_q),
        .stat_q   (stat_q),
        .exec_go  (exec_go),
        .exec_wr  (exec_wr),
        .exec_dev (exec_dev)
    );

    cfgch_osc_array #(.N_OSC(N_OSC), .OSC_RESET_ALL(OSC_RESET_ALL)) u_osc (
        .clk      (clk),
        .rst      (rst),
        .wr_go    (exec_go && exec_wr),
        .idx      (exec_dev),
        .wr_data  (dout_q),
        .rd_data  (osc_rd),
        .osc_flat (osc_setting)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            rtn_q  <= '0;
        end else begin
            if (reg_wr && (sel == SEL_DOUT))
                dout_q <= reg_wdata;
            if (exec_go && !exec_wr)
                rtn_q <= osc_rd;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CMD:  reg_rdata = cmd_q;
            SEL_STAT: reg_rdata = {30'd0, stat_q};
            SEL_DOUT: reg_rdata = dout_q;
            SEL_DRTN: reg_rdata = rtn_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfgch_checker.sv
module cfgch_checker #(
    parameter int N_OSC = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cmd_wr,
    input logic                  start_bit,
    input logic [31:0]           cmd_word,
    input logic [1:0]            stat,
    input logic [31:0]           rtn,
    input logic [N_OSC*32-1:0]   osc
);

    // R3: reserved and start bits of the stored command are always zero
    a_r3_clean_cmd: assert property (@(posedge clk) disable iff (rst)
        (cmd_word & 32'hBC0F_F000) == 32'h0);

    // R4: a command write leaves status cleared
    a_r4_stat_clear: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> (stat == 2'b00));

    // R5: a started command completes one cycle later unless overridden
    a_r5_done: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && start_bit) ##1 !cmd_wr |=> stat[0]);

    // R5: status holds without a command write
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |=> $stable(stat) || $rose(stat[0]));

    // R6: error never appears without done
    a_r6_err_with_done: assert property (@(posedge clk) disable iff (rst)
        stat[1] |-> stat[0]);

    // R9: a rejected command touches neither return data nor oscillators
    a_r9_no_side_effect: assert property (@(posedge clk) disable iff (rst)
        $rose(stat[1]) |-> $stable(osc) && $stable(rtn));

    // R10: a command without start never completes
    a_r10_no_start: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !start_bit) ##1 !cmd_wr |=> (stat == 2'b00));

endmodule

bind cfgch_top cfgch_checker #(.N_OSC(N_OSC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (reg_wr && (reg_sel == 2'd0)),
    .start_bit (reg_wdata[31]),
    .cmd_word  (cmd_q),
    .stat      (stat_q),
    .rtn       (rtn_q),
    .osc       (osc_setting)
);

// File: tb/tb_cfgch_top.sv
`timescale 1ns/1ps
module tb_cfgch_top;

    localparam int N = 4;
    localparam logic [511:0] RST_ALL =
        {384'h0, 32'd40000000, 32'd24576000, 32'd25000000, 32'd50000000};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_sel = 2'd0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [N*32-1:0] osc_setting;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] m_osc [N];
    logic [31:0] m_rtn;
    logic [31:0] m_dout;
    logic [31:0] m_cmd;

    always #2 clk = ~clk;

    cfgch_top #(.N_OSC(N), .OSC_RESET_ALL(RST_ALL)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .osc_setting(osc_setting)
    );

    function automatic logic [31:0] scrub(input logic [31:0] w);
        return w & ~32'hBC0F_F000;
    endfunction

    function automatic logic legal(input logic [31:0] w);
        return (w[25:20] == 6'd1) && (w[11:0] < 12'(N));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        reg_sel = s;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic check_osc(input string req);
        for (int i = 0; i < N; i++)
            check(req, osc_setting[i*32 +: 32], m_osc[i]);
    endtask

    // Runs one command: data-out, command, status in window and after completion.
    task automatic run_cmd(input logic [31:0] cmd, input logic [31:0] data);
        logic [31:0] v;
        logic [31:0] st;
        wr(2'd2, data);
        m_dout = data;
        wr(2'd0, cmd);
        m_cmd = scrub(cmd);
        rd(2'd1, v);
        check("R4 status window", v, 32'd0);
        @(negedge clk);
        st = 32'd0;
        if (cmd[31]) begin
            st = legal(cmd) ? 32'd1 : 32'd3;
            if (legal(cmd)) begin
                if (cmd[30]) m_osc[cmd[11:0]] = m_dout;
                else         m_rtn = m_osc[cmd[11:0]];
            end
        end
        rd(2'd1, v);
        check(cmd[31] ? (legal(cmd) ? "R5 done" : "R6 error") : "R10 no start", v, st);
        rd(2'd0, v);
        check("R3 command readback", v, m_cmd);
        rd(2'd3, v);
        check(legal(cmd) ? "R8 return data" : "R9 return kept", v, m_rtn);
        check_osc(legal(cmd) ? "R7 oscillator write" : "R9 oscillators kept");
        @(negedge clk);
        rd(2'd1, v);
        check("R5 status held", v, st);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned seed_sink;
        seed_sink = $urandom(32'h5EED_0042);
        for (int i = 0; i < N; i++) m_osc[i] = RST_ALL[i*32 +: 32];
        m_rtn = '0; m_dout = '0; m_cmd = 32'h0010_0000;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check("R1 command reset", v, 32'h0010_0000);
        rd(2'd1, v); check("R1 status reset", v, 32'd0);
        rd(2'd2, v); check("R1 data-out reset", v, 32'd0);
        rd(2'd3, v); check("R1 return reset", v, 32'd0);
        check_osc("R1 oscillator reset");

        // R2 writes to status and return ignored; data-out is read/write
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd3, 32'hDEAD_BEEF);
        rd(2'd1, v); check("R2 status write ignored", v, 32'd0);
        rd(2'd3, v); check("R2 return write ignored", v, 32'd0);
        wr(2'd2, 32'h1234_5678);
        rd(2'd2, v); check("R2 data-out readback", v, 32'h1234_5678);

        // Directed corners
        run_cmd(32'h8010_0002, 32'h0);                    // R8 legal read
        run_cmd(32'hC010_0003, 32'hA5A5_0001);            // R7 legal write, top index
        run_cmd(32'h8010_0003, 32'h0);                    // R8 read back written
        run_cmd(32'hC010_0000 | 32'(N), 32'h1111_1111);   // R6 index == N
        run_cmd(32'hC010_0FFF, 32'h2222_2222);            // R6 index 0xFFF
        run_cmd(32'hC210_0001, 32'h3333_3333);            // R6 func 0x21
        run_cmd(32'h8000_0001, 32'h0);                    // R6 func 0
        run_cmd(32'h4010_0001, 32'h4444_4444);            // R10 no start
        run_cmd(32'hFC1F_F001, 32'h5555_5555);            // R3 junk in reserved, legal write

        // Constrained random
        for (int k = 0; k < 300; k++) begin
            logic [31:0] c;
            logic [5:0]  f;
            logic [11:0] d;
            int unsigned r;
            f = ($urandom % 4 == 0) ? 6'($urandom) : 6'd1;
            r = $urandom % 8;
            if (r < 6)       d = 12'($urandom % (N + 2));
            else if (r == 6) d = 12'hFFF;
            else             d = 12'($urandom);
            c = ($urandom & 32'h3C0F_F000) | {2'b00, 4'h0, f, 8'h0, d};
            c[30] = 1'($urandom);
            c[31] = ($urandom % 8 != 0);
            run_cmd(c, $urandom);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule